// File: doc/BRIEF.md
# Single-Multiplier Symmetric Transposed FIR

This block is an N-tap FIR filter built as a small time-multiplexed datapath. It has one multiplier and a bank of partial-sum registers in transposed form. The coefficients are symmetric (h[k] = h[N-1-k]), so only the first ceil(N/2) of them are stored. Each product h[k]·x(n) is formed once on the shared multiplier. Two adders then feed that product into partial sum PS(k) and into its mirror PS(N-1-k) in the same cycle. A sample therefore costs ceil(N/2) cycles, where one multiply per tap would cost N.

The sweep walks k downward from the centre tap to tap 0. The lower lane produces PS(c), PS(c-1), and so on down to PS(1), and finally y(n). The upper lane fills the mirrored registers up to PS(N-1). Each register is overwritten in place. The lower lane keeps the old value of the register it has just replaced in a one-word carry register, and uses it on the next step.

Samples enter through a valid/ready port. Ready is low for the whole sweep. The result leaves on a one-cycle valid strobe, saturated to the output width. The partial sums carry ceil(log2 N) guard bits above the product width.

Top module: `fir_sym_tr`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0 and out_data_o is 0. All partial sums are zero, so the outputs that follow reset are computed as if every earlier input were zero.
- R2: A sample is accepted on a clock edge where in_valid_i and in_ready_o are both 1. in_ready_o is then 0 for exactly ceil(N/2) cycles. in_valid_i and in_data_i are ignored while ready is low.
- R3: out_valid_o is 1 for exactly one cycle. That cycle is the ceil(N/2)-th cycle after the accepting edge, and in_ready_o is already 1 in it.
- R4: out_data_o is y(n) = sum over i of h[i]·x(n-i), with h[i] = h[N-1-i]. Coefficient h[i] for i < ceil(N/2) is taken from COEFS bits [i*COEF_W +: COEF_W], as signed two's complement.
- R5: For odd N, the centre coefficient enters the sum exactly once.
- R6: The exact sum is saturated to OUT_W-bit two's complement. A sum above 2^(OUT_W-1)-1 gives that maximum, and a sum below -2^(OUT_W-1) gives that minimum.
- R7: out_data_o keeps its value between strobes.
- R8: Idle cycles between samples do not change the filter history.
- R9: For even N, both adder lanes are active in every step of the sweep, and R4 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block idle, sample can be accepted |
| in_data_i | input | DATA_W | Signed input sample |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | OUT_W | Saturated signed filter output |

## Verification
The bench builds two instances. The first has N=7 and OUT_W=12. It exercises the odd-length path, in which the centre tap runs alone on one lane in the first sweep step. Its narrow output makes both saturation limits reachable with full-scale inputs. The second has N=6 and OUT_W=16. It exercises the even-length path, in which the first step reads a register that the other lane overwrites on the same edge, and it never saturates. Both instances are compared sample by sample with a direct-form model, and an impulse reproduces the coefficient set.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;
  typedef enum logic {SW_IDLE = 1'b0, SW_RUN = 1'b1} sweep_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fir_sweep_ctrl.sv
module fir_sweep_ctrl
  import fir_sym_pkg::*;
#(
  parameter int HALF = 4,
  parameter int KW   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic          step_en_o,
  output logic          first_o,
  output logic          last_o,
  output logic [KW-1:0] k_o
);
  localparam logic [KW-1:0] KTOP = KW'(HALF - 1);

  sweep_e        st_q;
  logic [KW-1:0] k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SW_IDLE;
      k_q  <= '0;
    end else if (st_q == SW_IDLE) begin
      if (in_valid_i) begin
        st_q <= SW_RUN;
        k_q  <= KTOP;
      end
    end else if (k_q == '0) begin
      st_q <= SW_IDLE;
    end else begin
      k_q <= k_q - KW'(1);
    end
  end

  assign in_ready_o = (st_q == SW_IDLE);
  assign step_en_o  = (st_q == SW_RUN);
  assign first_o    = step_en_o && (k_q == KTOP);
  assign last_o     = step_en_o && (k_q == '0);
  assign k_o        = k_q;

  // R2: tap index walks down one per cycle until the sweep ends
  a_r2_k_descends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_o && !last_o) |=> (step_en_o && (k_o == $past(k_o) - KW'(1))));
endmodule

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
  parameter int                      HALF   = 4,
  parameter int                      COEF_W = 8,
  parameter int                      KW     = 2,
  parameter logic [HALF*COEF_W-1:0]  COEFS  = '0
) (
  input  logic        [KW-1:0]     k_i,
  output logic signed [COEF_W-1:0] coef_o
);
  logic signed [COEF_W-1:0] rom [HALF];

  for (genvar i = 0; i < HALF; i++) begin : g_rom
    assign rom[i] = COEFS[i*COEF_W +: COEF_W];
  end

  assign coef_o = rom[k_i];
endmodule

// File: rtl/fir_psum_bank.sv
module fir_psum_bank #(
  parameter int N_TAPS = 7,
  parameter int ACC_W  = 19,
  parameter int KW     = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_en_i,
  input  logic                    first_i,
  input  logic        [KW-1:0]    k_i,
  input  logic signed [ACC_W-1:0] prod_i,
  output logic signed [ACC_W-1:0] y_sum_o
);
  localparam int            IW   = $clog2(N_TAPS + 1);
  localparam logic [IW-1:0] LAST = IW'(N_TAPS - 1);

  logic signed [ACC_W-1:0] ps_q  [1:N_TAPS-1];
  logic signed [ACC_W-1:0] rd    [0:N_TAPS];
  logic signed [ACC_W-1:0] carry_q;
  logic signed [ACC_W-1:0] lo_op, hi_op, lo_sum, hi_sum;
  logic [IW-1:0]           k_ext, hi_idx;
  logic                    hi_act;

  // rd[0] and rd[N] read as zero: the ends of the chain
  assign rd[0]      = '0;
  assign rd[N_TAPS] = '0;
  for (genvar i = 1; i < N_TAPS; i++) begin : g_rd
    assign rd[i] = ps_q[i];
  end

  assign k_ext  = IW'(k_i);
  assign hi_idx = LAST - k_ext;
  assign hi_act = (hi_idx != k_ext);  // centre tap of odd N uses one lane

  // lower lane: old PS(k+1) comes from the register on the first step, else from carry
  assign lo_op  = first_i ? rd[k_ext + IW'(1)] : carry_q;
  // upper lane: PS(hi+1) has not been rewritten yet in this sweep
  assign hi_op  = rd[hi_idx + IW'(1)];
  assign lo_sum = prod_i + lo_op;
  assign hi_sum = prod_i + hi_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        carry_q <= '0;
    else if (step_en_i) carry_q <= rd[k_ext];
  end

  for (genvar i = 1; i < N_TAPS; i++) begin : g_ps
    logic hi_wr, lo_wr;
    assign hi_wr = step_en_i && hi_act && (hi_idx == IW'(i));
    assign lo_wr = step_en_i && (k_ext == IW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    ps_q[i] <= '0;
      else if (hi_wr) ps_q[i] <= hi_sum;
      else if (lo_wr) ps_q[i] <= lo_sum;
    end
  end

  assign y_sum_o = lo_sum;

  // R8: history is frozen outside a sweep
  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> $stable(ps_q[N_TAPS-1]));
endmodule

// File: rtl/fir_sym_tr.sv
module fir_sym_tr
  import fir_sym_pkg::*;
#(
  parameter int N_TAPS = 7,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int OUT_W  = 12,
  parameter logic [((N_TAPS+1)/2)*COEF_W-1:0] COEFS = 32'h28_14_FB_03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_data_o
);
  localparam int HALF   = (N_TAPS + 1) / 2;
  localparam int KW     = idx_w(HALF);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(N_TAPS);
  localparam int LW     = $clog2(HALF + 1) + 1;

  logic                     step_en, first, last;
  logic [KW-1:0]            k;
  logic signed [COEF_W-1:0] coef;
  logic signed [DATA_W-1:0] x_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, y_sum;
  logic [OUT_W-1:0]         y_sat, out_data_q;
  logic                     out_valid_q;
  logic                     accept;

  fir_sweep_ctrl #(.HALF(HALF), .KW(KW)) u_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o,
    .step_en_o(step_en), .first_o(first), .last_o(last), .k_o(k)
  );

  fir_coef_rom #(.HALF(HALF), .COEF_W(COEF_W), .KW(KW), .COEFS(COEFS)) u_rom (
    .k_i(k), .coef_o(coef)
  );

  assign accept = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     x_q <= '0;
    else if (accept) x_q <= in_data_i;
  end

  assign prod     = x_q * coef;
  assign prod_ext = ACC_W'(prod);

  fir_psum_bank #(.N_TAPS(N_TAPS), .ACC_W(ACC_W), .KW(KW)) u_bank (
    .clk_i, .rst_ni, .step_en_i(step_en), .first_i(first), .k_i(k),
    .prod_i(prod_ext), .y_sum_o(y_sum)
  );

  if (OUT_W < ACC_W) begin : g_sat
    logic [ACC_W-OUT_W:0] top;
    assign top   = y_sum[ACC_W-1:OUT_W-1];
    assign y_sat = ((top == '0) || (top == '1)) ? y_sum[OUT_W-1:0] :
                   y_sum[ACC_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
  end else begin : g_ext
    assign y_sat = OUT_W'(y_sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= last;
      if (last) out_data_q <= y_sat;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  // latency counter for the R3 window check
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lat_q <= '0;
    else if (accept)      lat_q <= '0;
    else if (!in_ready_o) lat_q <= lat_q + LW'(1);
  end

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !in_ready_o);
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  a_r3_ready_with_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> in_ready_o);
  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (lat_q == LW'(HALF)));
  a_r7_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));
endmodule

// File: tb/tb_fir_sym_tr.sv
`timescale 1ns/1ps
module tb_fir_sym_tr;
  logic clk = 1'b0;
  logic rst_ni;
  always #2.5 clk = ~clk;

  logic               in_valid;
  logic signed [7:0]  in_data;
  logic               rdy_o, rdy_e, vo, ve;
  logic signed [11:0] yo_d;
  logic signed [15:0] ye_d;

  fir_sym_tr #(.N_TAPS(7), .DATA_W(8), .COEF_W(8), .OUT_W(12),
               .COEFS(32'h28_14_FB_03)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy_o),
    .in_data_i(in_data), .out_valid_o(vo), .out_data_o(yo_d));

  fir_sym_tr #(.N_TAPS(6), .DATA_W(8), .COEF_W(8), .OUT_W(16),
               .COEFS(24'h19_F9_04)) dut_ev (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy_e),
    .in_data_i(in_data), .out_valid_o(ve), .out_data_o(ye_d));

  localparam int HO [7] = '{3, -5, 20, 40, 20, -5, 3};
  localparam int HE [6] = '{4, -7, 25, 25, -7, 4};

  // impulse stimulus and expected odd-length outputs
  localparam int NV = 7;
  localparam int VX [NV] = '{1, 0, 0, 0, 0, 0, 0};
  localparam int VY [NV] = '{3, -5, 20, 40, 20, -5, 3};

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  longint ho_h [7];
  longint he_h [6];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v, input int w);
    longint lim = 64'sd1 <<< (w - 1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim) return -lim;
    return v;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 7; i++) ho_h[i] = 0;
    for (int i = 0; i < 6; i++) he_h[i] = 0;
  endtask

  task automatic push(input int x, input bit junk, output longint got);
    longint eo, ee;
    @(negedge clk);
    in_data = 8'(x);
    in_valid = 1'b1;
    for (int i = 6; i > 0; i--) ho_h[i] = ho_h[i-1];
    for (int i = 5; i > 0; i--) he_h[i] = he_h[i-1];
    ho_h[0] = x;
    he_h[0] = x;
    eo = 0;
    ee = 0;
    for (int i = 0; i < 7; i++) eo += HO[i] * ho_h[i];
    for (int i = 0; i < 6; i++) ee += HE[i] * he_h[i];
    eo = sat(eo, 12);
    ee = sat(ee, 16);
    @(negedge clk);
    chk(rdy_o == 1'b0 && rdy_e == 1'b0, "R2 busy after accept", {rdy_o, rdy_e}, 0);
    if (junk) begin
      in_valid = 1'b1;
      in_data = 8'sd99;
    end else in_valid = 1'b0;
    got = 0;
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      if (c == 2) in_valid = 1'b0;
      chk(vo == (c == 4), "R3 strobe odd", vo, (c == 4));
      chk(ve == (c == 3), "R3 strobe even", ve, (c == 3));
      chk(rdy_o == (c >= 4), "R2 ready odd", rdy_o, (c >= 4));
      if (c == 3) chk(ye_d == ee, "R9 even output", ye_d, ee);
      if (c == 4) begin
        chk(yo_d == eo, "R4 odd output", yo_d, eo);
        got = yo_d;
      end
      if (c == 5) chk(yo_d == eo && !vo, "R7 held output", yo_d, eo);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint got;
    int seed;
    in_valid = 1'b0;
    in_data = '0;
    rst_ni = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    chk(rdy_o && !vo && yo_d == 0, "R1 reset state", {rdy_o, vo}, 2);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rdy_o && rdy_e && !vo && !ve, "R1 idle after reset", {rdy_o, rdy_e, vo, ve}, 12);

    // table walk: impulse response, centre tap at index 3 must appear once
    for (int i = 0; i < NV; i++) begin
      push(VX[i], 1'b0, got);
      chk(got == VY[i], (i == 3) ? "R5 centre tap once" : "R4 impulse tap", got, VY[i]);
    end

    // mixed samples, junk driven during busy windows must be ignored
    seed = 17;
    for (int i = 0; i < 10; i++) begin
      seed = (seed * 73 + 41) % 256;
      push(seed - 128, i[0], got);
    end

    // R6 positive and negative saturation
    for (int i = 0; i < 8; i++) push(127, 1'b0, got);
    chk(got == 2047, "R6 saturate high", got, 2047);
    for (int i = 0; i < 8; i++) push(-128, 1'b0, got);
    chk(got == -2048, "R6 saturate low", got, -2048);

    // R8/R7: long idle gap, output held, history survives
    push(50, 1'b0, got);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!vo && yo_d == got, "R7 hold in gap", yo_d, got);
    end
    push(-30, 1'b0, got);
    push(7, 1'b1, got);

    // R1: mid-run reset clears history
    @(negedge clk);
    rst_ni = 1'b0;
    clear_model();
    repeat (2) @(negedge clk);
    chk(rdy_o && !vo && yo_d == 0, "R1 mid-run reset", yo_d, 0);
    rst_ni = 1'b1;
    push(10, 1'b0, got);
    chk(got == 30, "R1 zero history", got, 30);
    push(0, 1'b0, got);
    chk(got == -50, "R1 zero history second", got, -50);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule